// File: doc/BRIEF.md
# Address Function Tag Generator

This block sits between the core of a small 8-bit processor and its external bus. In every cycle the core raises at most one access-class request: opcode fetch, vector fetch, parameter-stack relative, return-stack relative, general data, direct page, or DMA. Alongside the request the core supplies a 16-bit logical address and the extension bits of the widened pointer registers. The block turns these into a 24-bit physical bus address. The top three bits are a function tag that names the source of the access, the next five bits are an extension field, and the low sixteen bits are the logical address. Because each tag selects its own 2 MB space, caches and decoders further out can separate code, stack, direct-page and DMA traffic by decoding the tag alone.

The direct-page base is held in an internal 8-bit register that the core loads through a write strobe. A direct-page access uses that register as its high address byte and the operand as its low byte, and it always lands in the lowest 64K of its space. The tag, extension and address are registered together, so the bus sees them one clock after the request, on the same edge as the address-valid strobe.

Top module: `addr_tag_gen`

## Requirements
- R1: While reset is held, addrValid is 0 and busAddr is 0. The direct-page register also resets to 0.
- R2: An opcode fetch produces tag 3'b000 with extension pcExt. A vector fetch produces tag 3'b001 with extension 0.
- R3: A parameter-stack access produces tag 3'b010 with extension uExt. A return-stack access produces tag 3'b011 with extension sExt.
- R4: A general-data access produces tag 3'b100. Its extension comes from idxSel: 2'b01 takes xExt, 2'b10 takes yExt, and 2'b00 (absolute) or 2'b11 gives 0.
- R5: A direct-page access produces tag 3'b101 with extension 0. Its address is {dpReg, logicalAddr[7:0]}, and logicalAddr[15:8] has no effect.
- R6: When dpWrEn is high, dpWrData is loaded into the direct-page register at the clock edge. A direct-page access in that same cycle still uses the previous register value.
- R7: A DMA access produces tag 3'b110 when dmaChan is 0 and 3'b111 when dmaChan is 1, with extension dmaExt.
- R8: busAddr is laid out as tag in bits [23:21], extension in bits [20:16] and address in bits [15:0]. For every class except direct page, bits [15:0] equal logicalAddr.
- R9: In a cycle with no request, addrValid is 0 after the next edge and busAddr holds its previous value.
- R10: The result of a request appears on busAddr one clock edge after the request, with addrValid high on that same edge.
- R11: If more than one request is raised, the access is served in this fixed priority order: DMA, vector, fetch, return stack, parameter stack, direct page, data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqFetch | input | 1 | Opcode fetch request |
| reqVector | input | 1 | Vector fetch request |
| reqParam | input | 1 | Parameter-stack relative request |
| reqReturn | input | 1 | Return-stack relative request |
| reqData | input | 1 | General data request |
| reqDirect | input | 1 | Direct-page request |
| reqDma | input | 1 | DMA request |
| idxSel | input | 2 | Data index source: 00 absolute, 01 X, 10 Y, 11 none |
| dmaChan | input | 1 | DMA channel, selects tag 110 or 111 |
| logicalAddr | input | 16 | Logical address or operand |
| pcExt | input | 5 | Program counter extension bits |
| uExt | input | 5 | Parameter-stack pointer extension bits |
| sExt | input | 5 | Return-stack pointer extension bits |
| xExt | input | 5 | X index extension bits |
| yExt | input | 5 | Y index extension bits |
| dmaExt | input | 5 | DMA extension bits |
| dpWrEn | input | 1 | Direct-page register load strobe |
| dpWrData | input | 8 | Direct-page register load value |
| busAddr | output | 24 | Registered physical bus address |
| addrValid | output | 1 | Bus address valid strobe |

## Verification
The hardest case to reach is a direct-page register load that lands in the same cycle as a direct-page access. In that case the old base must appear on the bus, and the new base must appear only on the following access. The bench first loads a known base. It then raises the load strobe with a different value in the same cycle as a direct request, and follows at once with a second direct request. Because each access has a distinct low byte and a junk high byte, the bench can tell which base was used and confirm that the operand's high byte was dropped.

// File: rtl/addr_tag_pkg.sv
package addr_tag_pkg;

  localparam int TAG_W = 3;

  typedef enum logic [TAG_W-1:0] {
    TAG_CODE  = 3'b000,
    TAG_VECT  = 3'b001,
    TAG_PSTK  = 3'b010,
    TAG_RSTK  = 3'b011,
    TAG_DATA  = 3'b100,
    TAG_DPAGE = 3'b101,
    TAG_DMA0  = 3'b110,
    TAG_DMA1  = 3'b111
  } tag_e;

  typedef enum logic [2:0] {
    EXT_ZERO,
    EXT_PC,
    EXT_U,
    EXT_S,
    EXT_X,
    EXT_Y,
    EXT_DMA
  } extSel_e;

  typedef struct packed {
    logic    load;
    tag_e    tag;
    extSel_e extSel;
    logic    dpForm;
  } ctrlStb_t;

endpackage

// File: rtl/addr_tag_ctrl.sv
module addr_tag_ctrl
  import addr_tag_pkg::*;
(
  input  logic       reqFetch,
  input  logic       reqVector,
  input  logic       reqParam,
  input  logic       reqReturn,
  input  logic       reqData,
  input  logic       reqDirect,
  input  logic       reqDma,
  input  logic [1:0] idxSel,
  input  logic       dmaChan,
  output ctrlStb_t   stb
);

  extSel_e dataSel;

  always_comb begin
    unique case (idxSel)
      2'b01:   dataSel = EXT_X;
      2'b10:   dataSel = EXT_Y;
      default: dataSel = EXT_ZERO;
    endcase
  end

  // Fixed priority: DMA, vector, fetch, return, param, direct, data
  always_comb begin
    stb.load   = 1'b1;
    stb.tag    = TAG_DATA;
    stb.extSel = EXT_ZERO;
    stb.dpForm = 1'b0;
    if (reqDma) begin
      stb.tag    = dmaChan ? TAG_DMA1 : TAG_DMA0;
      stb.extSel = EXT_DMA;
    end else if (reqVector) begin
      stb.tag    = TAG_VECT;
      stb.extSel = EXT_ZERO;
    end else if (reqFetch) begin
      stb.tag    = TAG_CODE;
      stb.extSel = EXT_PC;
    end else if (reqReturn) begin
      stb.tag    = TAG_RSTK;
      stb.extSel = EXT_S;
    end else if (reqParam) begin
      stb.tag    = TAG_PSTK;
      stb.extSel = EXT_U;
    end else if (reqDirect) begin
      stb.tag    = TAG_DPAGE;
      stb.extSel = EXT_ZERO;
      stb.dpForm = 1'b1;
    end else if (reqData) begin
      stb.tag    = TAG_DATA;
      stb.extSel = dataSel;
    end else begin
      stb.load   = 1'b0;
    end
  end

endmodule

// File: rtl/addr_tag_dpath.sv
module addr_tag_dpath
  import addr_tag_pkg::*;
#(
  parameter int EXT_W   = 5,
  parameter int LADDR_W = 16,
  localparam int DP_W    = LADDR_W / 2,
  localparam int PADDR_W = TAG_W + EXT_W + LADDR_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStb_t           stb,
  input  logic [LADDR_W-1:0] logicalAddr,
  input  logic [EXT_W-1:0]   pcExt,
  input  logic [EXT_W-1:0]   uExt,
  input  logic [EXT_W-1:0]   sExt,
  input  logic [EXT_W-1:0]   xExt,
  input  logic [EXT_W-1:0]   yExt,
  input  logic [EXT_W-1:0]   dmaExt,
  input  logic               dpWrEn,
  input  logic [DP_W-1:0]    dpWrData,
  output logic [PADDR_W-1:0] busAddr,
  output logic               addrValid
);

  localparam int TAG_LO = EXT_W + LADDR_W;

  logic [DP_W-1:0]    dpReg;
  logic [EXT_W-1:0]   extMux;
  logic [LADDR_W-1:0] addrMux;
  logic               pastValid;

  always_comb begin
    unique case (stb.extSel)
      EXT_PC:  extMux = pcExt;
      EXT_U:   extMux = uExt;
      EXT_S:   extMux = sExt;
      EXT_X:   extMux = xExt;
      EXT_Y:   extMux = yExt;
      EXT_DMA: extMux = dmaExt;
      default: extMux = '0;
    endcase
  end

  always_comb begin
    if (stb.dpForm) addrMux = {dpReg, logicalAddr[DP_W-1:0]};
    else            addrMux = logicalAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dpReg <= '0;
    else if (dpWrEn) dpReg <= dpWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busAddr   <= '0;
      addrValid <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      addrValid <= stb.load;
      pastValid <= 1'b1;
      if (stb.load) busAddr <= {stb.tag, extMux, addrMux};
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid && !addrValid |-> $stable(busAddr)); // R9
  AST_DP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid && $past(dpWrEn) |-> dpReg == $past(dpWrData)); // R6
  AST_DPAGE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid && busAddr[PADDR_W-1:TAG_LO] == TAG_DPAGE |-> busAddr[TAG_LO-1:LADDR_W] == '0); // R5
  AST_VECT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid && busAddr[PADDR_W-1:TAG_LO] == TAG_VECT |-> busAddr[TAG_LO-1:LADDR_W] == '0); // R2

endmodule

// File: rtl/addr_tag_gen.sv
module addr_tag_gen
  import addr_tag_pkg::*;
#(
  parameter int EXT_W   = 5,
  parameter int LADDR_W = 16,
  localparam int DP_W    = LADDR_W / 2,
  localparam int PADDR_W = TAG_W + EXT_W + LADDR_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqFetch,
  input  logic               reqVector,
  input  logic               reqParam,
  input  logic               reqReturn,
  input  logic               reqData,
  input  logic               reqDirect,
  input  logic               reqDma,
  input  logic [1:0]         idxSel,
  input  logic               dmaChan,
  input  logic [LADDR_W-1:0] logicalAddr,
  input  logic [EXT_W-1:0]   pcExt,
  input  logic [EXT_W-1:0]   uExt,
  input  logic [EXT_W-1:0]   sExt,
  input  logic [EXT_W-1:0]   xExt,
  input  logic [EXT_W-1:0]   yExt,
  input  logic [EXT_W-1:0]   dmaExt,
  input  logic               dpWrEn,
  input  logic [DP_W-1:0]    dpWrData,
  output logic [PADDR_W-1:0] busAddr,
  output logic               addrValid
);

  ctrlStb_t stb;
  logic     anyReq;
  logic     topPast;

  assign anyReq = reqFetch | reqVector | reqParam | reqReturn |
                  reqData | reqDirect | reqDma;

  addr_tag_ctrl u_ctrl (
    .reqFetch  (reqFetch),
    .reqVector (reqVector),
    .reqParam  (reqParam),
    .reqReturn (reqReturn),
    .reqData   (reqData),
    .reqDirect (reqDirect),
    .reqDma    (reqDma),
    .idxSel    (idxSel),
    .dmaChan   (dmaChan),
    .stb       (stb)
  );

  addr_tag_dpath #(.EXT_W(EXT_W), .LADDR_W(LADDR_W)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .logicalAddr (logicalAddr),
    .pcExt       (pcExt),
    .uExt        (uExt),
    .sExt        (sExt),
    .xExt        (xExt),
    .yExt        (yExt),
    .dmaExt      (dmaExt),
    .dpWrEn      (dpWrEn),
    .dpWrData    (dpWrData),
    .busAddr     (busAddr),
    .addrValid   (addrValid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) topPast <= 1'b0;
    else        topPast <= 1'b1;
  end

  AST_REQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    topPast && anyReq |=> addrValid); // R10
  AST_NOREQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    topPast && !anyReq |=> !addrValid); // R9
  AST_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    topPast && anyReq && !reqDirect |=> busAddr[LADDR_W-1:0] == $past(logicalAddr)); // R8

endmodule

// File: tb/addr_tag_gen_tb.sv
module addr_tag_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqFetch = 0, reqVector = 0, reqParam = 0, reqReturn = 0;
  logic        reqData = 0, reqDirect = 0, reqDma = 0;
  logic [1:0]  idxSel = 2'b00;
  logic        dmaChan = 1'b0;
  logic [15:0] logicalAddr = '0;
  logic [4:0]  pcExt = 5'h03, uExt = 5'h0A, sExt = 5'h15, xExt = 5'h1C, yExt = 5'h07, dmaExt = 5'h19;
  logic        dpWrEn = 1'b0;
  logic [7:0]  dpWrData = '0;
  logic [23:0] busAddr;
  logic        addrValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  addr_tag_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .reqFetch(reqFetch), .reqVector(reqVector), .reqParam(reqParam),
    .reqReturn(reqReturn), .reqData(reqData), .reqDirect(reqDirect),
    .reqDma(reqDma), .idxSel(idxSel), .dmaChan(dmaChan),
    .logicalAddr(logicalAddr), .pcExt(pcExt), .uExt(uExt), .sExt(sExt),
    .xExt(xExt), .yExt(yExt), .dmaExt(dmaExt),
    .dpWrEn(dpWrEn), .dpWrData(dpWrData),
    .busAddr(busAddr), .addrValid(addrValid)
  );

  function automatic logic [23:0] mk(input logic [2:0] t, input logic [4:0] e, input logic [15:0] a);
    return {t, e, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearReq();
    reqFetch = 0; reqVector = 0; reqParam = 0; reqReturn = 0;
    reqData = 0; reqDirect = 0; reqDma = 0; dpWrEn = 0;
  endtask

  // drive at negedge, result registered at posedge, sample at next negedge
  task automatic stepCheck(input string req, input logic [23:0] exp);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, addrValid}, 32'd1);
    chk({req, " addr"}, {8'd0, busAddr}, {8'd0, exp});
    clearReq();
  endtask

  task automatic test_reset();
    chk("R1 valid", {31'd0, addrValid}, 32'd0);
    chk("R1 addr", {8'd0, busAddr}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    logicalAddr = 16'h4321; reqDirect = 1;
    stepCheck("R1 dp reset", mk(3'b101, 5'h00, 16'h0021));
  endtask

  task automatic test_fetch_vector();
    logicalAddr = 16'hC0DE; reqFetch = 1;
    stepCheck("R2 fetch", mk(3'b000, pcExt, 16'hC0DE));
    logicalAddr = 16'hFFFE; reqVector = 1;
    stepCheck("R2 vector", mk(3'b001, 5'h00, 16'hFFFE));
  endtask

  task automatic test_stacks();
    logicalAddr = 16'h0F10; reqParam = 1;
    stepCheck("R3 param", mk(3'b010, uExt, 16'h0F10));
    logicalAddr = 16'h01FF; reqReturn = 1;
    stepCheck("R3 return", mk(3'b011, sExt, 16'h01FF));
  endtask

  task automatic test_data();
    logicalAddr = 16'h8001; reqData = 1; idxSel = 2'b00;
    stepCheck("R4 absolute", mk(3'b100, 5'h00, 16'h8001));
    logicalAddr = 16'h2345; reqData = 1; idxSel = 2'b01;
    stepCheck("R4 X", mk(3'b100, xExt, 16'h2345));
    logicalAddr = 16'h6789; reqData = 1; idxSel = 2'b10;
    stepCheck("R4 Y", mk(3'b100, yExt, 16'h6789));
    logicalAddr = 16'hABCD; reqData = 1; idxSel = 2'b11;
    stepCheck("R4 sel11", mk(3'b100, 5'h00, 16'hABCD));
    idxSel = 2'b00;
  endtask

  task automatic test_direct();
    dpWrEn = 1; dpWrData = 8'h5A;
    @(negedge clk); clearReq();
    logicalAddr = 16'hEE34; reqDirect = 1;
    stepCheck("R5 direct hi ignored", mk(3'b101, 5'h00, 16'h5A34));
    // R6 load and access in same cycle: old base used
    logicalAddr = 16'h12AB; reqDirect = 1; dpWrEn = 1; dpWrData = 8'h3C;
    stepCheck("R6 same cycle old", mk(3'b101, 5'h00, 16'h5AAB));
    logicalAddr = 16'h9977; reqDirect = 1;
    stepCheck("R6 new base", mk(3'b101, 5'h00, 16'h3C77));
  endtask

  task automatic test_dma();
    logicalAddr = 16'h1111; reqDma = 1; dmaChan = 0;
    stepCheck("R7 dma0", mk(3'b110, dmaExt, 16'h1111));
    logicalAddr = 16'h2222; reqDma = 1; dmaChan = 1;
    stepCheck("R7 dma1", mk(3'b111, dmaExt, 16'h2222));
    dmaChan = 0;
  endtask

  task automatic test_idle();
    logicalAddr = 16'h7777; reqParam = 1;
    stepCheck("R10 param", mk(3'b010, uExt, 16'h7777));
    logicalAddr = 16'h0000;
    @(negedge clk);
    chk("R9 idle valid", {31'd0, addrValid}, 32'd0);
    chk("R9 idle hold", {8'd0, busAddr}, {8'd0, mk(3'b010, uExt, 16'h7777)});
  endtask

  task automatic test_priority();
    logicalAddr = 16'h3030; reqFetch = 1; reqDma = 1; reqData = 1;
    stepCheck("R11 dma wins", mk(3'b110, dmaExt, 16'h3030));
    logicalAddr = 16'h4040; reqFetch = 1; reqVector = 1; reqParam = 1;
    stepCheck("R11 vector wins", mk(3'b001, 5'h00, 16'h4040));
    logicalAddr = 16'h5050; reqReturn = 1; reqParam = 1; reqDirect = 1;
    stepCheck("R11 return wins", mk(3'b011, sExt, 16'h5050));
    logicalAddr = 16'h6060; reqDirect = 1; reqData = 1; idxSel = 2'b01;
    stepCheck("R11 direct wins", mk(3'b101, 5'h00, 16'h3C60));
    idxSel = 2'b00;
  endtask

  initial begin
    #1;
    test_reset();
    test_fetch_vector();
    test_stacks();
    test_data();
    test_direct();
    test_dma();
    test_idle();
    test_priority();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule